// File: doc/BRIEF.md
# I/O Translation Table Walker

This unit turns one DMA virtual address into a 40-bit physical address by walking a single-level, memory-resident translation table. A request names one of 32 table descriptors held in a local register file, plus the low 40 bits of the VA and a write flag. The descriptor supplies the table base, a page-number offset, a page-size code and a table-size code. From these the unit derives the adjusted page number and range-checks it. It then computes where the 8-byte table entry sits in memory and fetches it with one read.

The entry comes back in little-endian byte order. The unit reverses it, checks the valid and write-permission bits, and merges the entry's page frame with the VA's in-page offset. Every request ends in exactly one response: either a translation or a fault code. The unit serves one request at a time. Its descriptors are loaded through a simple write port.

Top module: `iotsb_walker`

## Requirements
- R1: After reset, and after a reset asserted mid-walk, req_ready is 1 while rsp_valid and mem_req_valid are 0. All descriptors clear to zero, so the valid bit reads 0.
- R2: req_ready is 1 only while idle. It drops the cycle after a request is accepted and stays low until the response has been given. A request presented while the unit is busy is ignored.
- R3: Descriptor layout: bit 63 valid, bits 59:34 table base (PA = base << 13), bits 33:7 offset, bits 6:4 page-size code, bits 3:0 table-size code. A clear valid bit gives fault 1.
- R4: Page-size codes 2, 4, 6 and 7 give fault 2. Code n selects a page of 2^(13+3n) bytes.
- R5: The page number is VA[39:0] >> (13+3n). A page number below the offset gives fault 3. A page number equal to the offset is accepted.
- R6: The adjusted page number is page number minus offset. If it is greater than 0x400 << table-size, the result is fault 4. If it is equal, the request is accepted.
- R7: The unit issues exactly one read, at base + adjusted page number × 8. It holds mem_req_valid and the address stable until mem_req_ready.
- R8: The returned word is byte-reversed before decoding. Entry layout: bit 0 valid, bit 1 write-allowed, bit 2 key-valid, bits 38:13 page frame. A clear valid bit gives fault 5.
- R9: A write request to an entry whose write-allowed bit is clear gives fault 6. A read request to the same entry succeeds.
- R10: On success, the fault code is 0 and rsp_pa = (frame << 13) OR (VA AND (2^(13+3n) − 1)). rsp_key_valid reports the key-valid bit.
- R11: A descriptor-stage fault (codes 1–4) responds two cycles after acceptance, with no memory read. rsp_valid is a one-cycle pulse. On any fault rsp_pa and rsp_key_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_we | input | 1 | Descriptor write strobe |
| desc_waddr | input | 5 | Descriptor index to write |
| desc_wdata | input | 64 | Descriptor word |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle, request accepted |
| req_va | input | 40 | VA bits 39:0 |
| req_write | input | 1 | Request is a DMA write |
| req_tsb | input | 5 | Descriptor index for this request |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Entry address |
| mem_rsp_valid | input | 1 | Entry data returning |
| mem_rsp_data | input | 64 | Entry word, little-endian |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 40 | Translated physical address |
| rsp_fault | output | 3 | 0 none, 1 bad descriptor, 2 bad page size, 3 underflow, 4 out of range, 5 bad entry, 6 write protect |
| rsp_key_valid | output | 1 | Entry key-valid bit |

## Verification
Count cycles from the clock edge that accepts a request. A descriptor-stage fault is visible after two edges. The memory read request appears after two edges and is held through any stall. The response follows two edges after the read handshake, so an unstalled walk takes four cycles plus the stall length. The bench drives stimulus on falling edges and counts falling edges from acceptance. It compares that count with the expected latency, and it checks the read address on the falling edge where it raises ready.

// File: rtl/iotsb_pkg.sv
package iotsb_pkg;
  localparam int PA_W    = 40;
  localparam int WORD_W  = 64;
  localparam int PG_LSB  = 13;
  localparam int OFF_W   = 27;
  localparam int BASE_W  = 26;
  localparam int NPG_LOG = 10;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_DESC_INV = 3'd1,
    FLT_PGSZ     = 3'd2,
    FLT_UNDER    = 3'd3,
    FLT_RANGE    = 3'd4,
    FLT_ENT_INV  = 3'd5,
    FLT_WPROT    = 3'd6
  } fault_e;

  typedef struct packed {
    logic              vld;
    logic [2:0]        rsvd;
    logic [BASE_W-1:0] base;
    logic [OFF_W-1:0]  off;
    logic [2:0]        pgsz;
    logic [3:0]        tbl;
  } desc_t;

  typedef struct packed {
    logic [15:0] dkey;
    logic [8:0]  rsvd_hi;
    logic [25:0] frame;
    logic [6:0]  rsvd_lo;
    logic [2:0]  fnum;
    logic        key;
    logic        wr;
    logic        vld;
  } entry_t;
endpackage

// File: rtl/iotsb_desc_file.sv
module iotsb_desc_file #(
  parameter int DEPTH = 32,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] regs [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic hit;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= '0;
      else if (hit) regs[g] <= wdata;
    end
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/iotsb_page_calc.sv
module iotsb_page_calc
  import iotsb_pkg::*;
(
  input  desc_t           desc,
  input  logic [PA_W-1:0] va,
  output fault_e          fault,
  output logic [PA_W-1:0] ent_addr,
  output logic [PA_W-1:0] off_mask
);
  logic [5:0]      shamt;
  logic [PA_W-1:0] pn, adj, npages, base_pa, off_ext;
  logic            rsv_code;
  logic            unused_desc;

  assign shamt    = 6'(PG_LSB) + 6'(desc.pgsz) * 6'd3;
  assign pn       = va >> shamt;
  assign off_ext  = PA_W'(desc.off);
  assign adj      = pn - off_ext;
  assign npages   = (PA_W'(1) << NPG_LOG) << desc.tbl;
  assign base_pa  = {{(PA_W-BASE_W-PG_LSB){1'b0}}, desc.base, {PG_LSB{1'b0}}};
  assign ent_addr = (adj << 3) + base_pa;
  assign off_mask = (PA_W'(1) << shamt) - PA_W'(1);
  assign unused_desc = ^desc.rsvd;

  always_comb begin
    unique case (desc.pgsz)
      3'd2, 3'd4, 3'd6, 3'd7: rsv_code = 1'b1;
      default:                rsv_code = 1'b0;
    endcase
  end

  always_comb begin
    if (!desc.vld)             fault = FLT_DESC_INV;
    else if (rsv_code)         fault = FLT_PGSZ;
    else if (pn < off_ext)     fault = FLT_UNDER;
    else if (adj > npages)     fault = FLT_RANGE;
    else                       fault = FLT_NONE;
  end
endmodule

// File: rtl/iotsb_entry_dec.sv
module iotsb_entry_dec
  import iotsb_pkg::*;
(
  input  logic [WORD_W-1:0] raw,
  input  logic [PA_W-1:0]   va,
  input  logic [PA_W-1:0]   off_mask,
  input  logic              is_write,
  output fault_e            fault,
  output logic [PA_W-1:0]   pa,
  output logic              key_vld
);
  localparam int NB = WORD_W / 8;

  logic [WORD_W-1:0] swapped;
  entry_t            ent;
  logic              unused_ent;

  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign swapped[8*b +: 8] = raw[8*(NB-1-b) +: 8];
  end

  assign ent        = entry_t'(swapped);
  assign pa         = {{(PA_W-26-PG_LSB){1'b0}}, ent.frame, {PG_LSB{1'b0}}} | (va & off_mask);
  assign key_vld    = ent.key;
  assign unused_ent = ^{ent.dkey, ent.rsvd_hi, ent.rsvd_lo, ent.fnum};

  always_comb begin
    if (!ent.vld)                fault = FLT_ENT_INV;
    else if (is_write && !ent.wr) fault = FLT_WPROT;
    else                         fault = FLT_NONE;
  end
endmodule

// File: rtl/iotsb_walker.sv
module iotsb_walker
  import iotsb_pkg::*;
#(
  parameter int TSB_CNT = 32,
  localparam int TSB_AW = $clog2(TSB_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_we,
  input  logic [TSB_AW-1:0] desc_waddr,
  input  logic [WORD_W-1:0] desc_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic [TSB_AW-1:0] req_tsb,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [2:0]        rsp_fault,
  output logic              rsp_key_valid
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC, ST_MREQ, ST_MWAIT, ST_RESP
  } state_e;

  state_e             state_q, state_d;
  logic [PA_W-1:0]    va_q, addr_q, mask_q, pa_q;
  logic               wr_q, key_q;
  logic [TSB_AW-1:0]  tsb_q;
  fault_e             fault_q;

  logic [WORD_W-1:0]  desc_raw;
  fault_e             calc_fault, ent_fault;
  logic [PA_W-1:0]    calc_addr, calc_mask, ent_pa;
  logic               ent_key;
  logic               ld_req, ld_walk, ld_ent;

  iotsb_desc_file #(.DEPTH(TSB_CNT), .W(WORD_W)) u_desc (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (desc_we),
    .waddr (desc_waddr),
    .wdata (desc_wdata),
    .raddr (tsb_q),
    .rdata (desc_raw)
  );

  iotsb_page_calc u_calc (
    .desc     (desc_t'(desc_raw)),
    .va       (va_q),
    .fault    (calc_fault),
    .ent_addr (calc_addr),
    .off_mask (calc_mask)
  );

  iotsb_entry_dec u_dec (
    .raw      (mem_rsp_data),
    .va       (va_q),
    .off_mask (mask_q),
    .is_write (wr_q),
    .fault    (ent_fault),
    .pa       (ent_pa),
    .key_vld  (ent_key)
  );

  assign ld_req  = (state_q == ST_IDLE) && req_valid;
  assign ld_walk = (state_q == ST_DESC);
  assign ld_ent  = (state_q == ST_MWAIT) && mem_rsp_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_DESC;
      ST_DESC:  state_d = (calc_fault == FLT_NONE) ? ST_MREQ : ST_RESP;
      ST_MREQ:  if (mem_req_ready) state_d = ST_MWAIT;
      ST_MWAIT: if (mem_rsp_valid) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      wr_q  <= 1'b0;
      tsb_q <= '0;
    end else if (ld_req) begin
      va_q  <= req_va;
      wr_q  <= req_write;
      tsb_q <= req_tsb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
    end else if (ld_walk) begin
      addr_q <= calc_addr;
      mask_q <= calc_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= FLT_NONE;
      pa_q    <= '0;
      key_q   <= 1'b0;
    end else if (ld_walk) begin
      fault_q <= calc_fault;
      pa_q    <= '0;
      key_q   <= 1'b0;
    end else if (ld_ent) begin
      fault_q <= ent_fault;
      pa_q    <= (ent_fault == FLT_NONE) ? ent_pa : '0;
      key_q   <= (ent_fault == FLT_NONE) && ent_key;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = fault_q;
  assign rsp_key_valid = key_q;
endmodule

// File: rtl/iotsb_walker_chk.sv
module iotsb_walker_chk #(
  parameter int PA_W = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_pa,
  input logic [2:0]      rsp_fault,
  input logic            rsp_key_valid
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R2
  AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R2
  AST_DESC_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !mem_req_valid && !rsp_valid); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_FAULT_CLEARS_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 3'd0) |-> (rsp_pa == '0) && !rsp_key_valid); // R11
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R7
  AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R7
  AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= 3'd6)); // R8
endmodule

bind iotsb_walker iotsb_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_pa        (rsp_pa),
  .rsp_fault     (rsp_fault),
  .rsp_key_valid (rsp_key_valid)
);

// File: tb/iotsb_walker_test.sv
module iotsb_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_we = 1'b0;
  logic [4:0]  desc_waddr = '0;
  logic [63:0] desc_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [4:0]  req_tsb = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [39:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic [39:0] rsp_pa;
  logic [2:0]  rsp_fault;
  logic        rsp_key_valid;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  iotsb_walker uut (.*);

  typedef struct packed {
    logic [4:0]  tsb;
    logic [39:0] va;
    logic        wr;
    logic [63:0] ent;
    logic [3:0]  stall;
    logic [2:0]  ef;
    logic [39:0] epa;
    logic        ek;
    logic [39:0] eaddr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{5'd0, 40'h4123,       1'b0, 64'hABCDE001,    4'd0, 3'd0, 40'hABCDE123,    1'b0, 40'h2010},
    '{5'd0, 40'h4123,       1'b1, 64'hABCDE001,    4'd0, 3'd6, 40'h0,           1'b0, 40'h2010},
    '{5'd0, 40'h4123,       1'b1, 64'hABCDE007,    4'd2, 3'd0, 40'hABCDE123,    1'b1, 40'h2010},
    '{5'd0, 40'h4123,       1'b0, 64'hABCDE006,    4'd0, 3'd5, 40'h0,           1'b0, 40'h2010},
    '{5'd1, 40'h4123,       1'b0, 64'h0,           4'd0, 3'd1, 40'h0,           1'b0, 40'h0},
    '{5'd2, 40'h4123,       1'b0, 64'h0,           4'd0, 3'd2, 40'h0,           1'b0, 40'h0},
    '{5'd3, 40'h4123,       1'b0, 64'h0,           4'd0, 3'd2, 40'h0,           1'b0, 40'h0},
    '{5'd8, 40'h4123,       1'b0, 64'h0,           4'd0, 3'd2, 40'h0,           1'b0, 40'h0},
    '{5'd9, 40'h4123,       1'b0, 64'h0,           4'd0, 3'd2, 40'h0,           1'b0, 40'h0},
    '{5'd4, 40'h30000,      1'b0, 64'h0,           4'd0, 3'd3, 40'h0,           1'b0, 40'h0},
    '{5'd4, 40'h71234,      1'b0, 64'h550001,      4'd1, 3'd0, 40'h551234,      1'b0, 40'h20010},
    '{5'd4, 40'h50000,      1'b0, 64'h550001,      4'd0, 3'd0, 40'h550000,      1'b0, 40'h20000},
    '{5'd5, 40'h800000,     1'b0, 64'h2001,        4'd0, 3'd0, 40'h2000,        1'b0, 40'h2000},
    '{5'd5, 40'h802000,     1'b0, 64'h0,           4'd0, 3'd4, 40'h0,           1'b0, 40'h0},
    '{5'd6, 40'h123456789A, 1'b0, 64'h7000000001,  4'd3, 3'd0, 40'h700456789A,  1'b0, 40'h4918},
    '{5'd7, 40'hC00001,     1'b0, 64'h40000001,    4'd0, 3'd0, 40'h40000001,    1'b0, 40'h18}
  };

  int          got_lat;
  logic [2:0]  got_fault;
  logic [39:0] got_pa;
  logic        got_key;
  logic [39:0] got_addr;
  int          got_nreq;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_desc(input logic v, input logic [25:0] base,
                                          input logic [26:0] off, input logic [2:0] pg,
                                          input logic [3:0] tbl);
    return {v, 3'b000, base, off, pg, tbl};
  endfunction

  function automatic logic [63:0] to_le(input logic [63:0] w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = w[8*(7-b) +: 8];
    return r;
  endfunction

  function automatic string rtag(input logic [2:0] ef);
    case (ef)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic wr_desc(input int idx, input logic [63:0] d);
    @(negedge clk);
    desc_we = 1'b1; desc_waddr = 5'(idx); desc_wdata = d;
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic walk(input vec_t v, input bit poke);
    int cyc;
    int stall;
    bit got;
    cyc = 1; stall = int'(v.stall); got = 1'b0;
    got_nreq = 0; got_addr = '0; got_lat = -1;
    got_fault = 'x; got_pa = 'x; got_key = 1'bx;
    @(negedge clk);
    req_valid = 1'b1; req_va = v.va; req_write = v.wr; req_tsb = v.tsb;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy after accept", 64'(req_ready), 64'd0);
    if (poke) begin req_valid = 1'b1; req_tsb = 5'd1; end
    while (!got && cyc < 40) begin
      if (rsp_valid) begin
        got = 1'b1; got_lat = cyc;
        got_fault = rsp_fault; got_pa = rsp_pa; got_key = rsp_key_valid;
      end
      mem_rsp_valid = 1'b0;
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = to_le(v.ent);
      end else if (mem_req_valid) begin
        if (stall > 0) stall--;
        else begin
          mem_req_ready = 1'b1;
          got_addr = mem_req_addr;
          got_nreq++;
        end
      end
      if (!got) begin
        @(negedge clk);
        cyc++;
        if (poke && cyc == 2) req_valid = 1'b0;
      end
    end
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    string t;
    int elat;
    t = rtag(v.ef);
    walk(v, poke);
    elat = (v.ef inside {3'd1, 3'd2, 3'd3, 3'd4}) ? 2 : 4 + int'(v.stall);
    chk({t, " fault code"}, 64'(got_fault), 64'(v.ef));
    chk({t, " pa"}, 64'(got_pa), 64'(v.epa));
    chk({t, " R10 key valid"}, 64'(got_key), 64'(v.ek));
    chk("R11 latency", 64'(got_lat), 64'(elat));
    if (elat == 2) begin
      chk("R11 no memory read on descriptor fault", 64'(got_nreq), 64'd0);
    end else begin
      chk("R7 one memory read", 64'(got_nreq), 64'd1);
      chk("R7 entry address", 64'(got_addr), 64'(v.eaddr));
    end
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 no rsp after reset", 64'(rsp_valid), 64'd0);
    chk("R1 no read after reset", 64'(mem_req_valid), 64'd0);

    wr_desc(0, mk_desc(1'b1, 26'h1,  27'd0, 3'd0, 4'd0));
    wr_desc(1, mk_desc(1'b0, 26'h1,  27'd0, 3'd0, 4'd0));
    wr_desc(2, mk_desc(1'b1, 26'h0,  27'd0, 3'd2, 4'd0));
    wr_desc(3, mk_desc(1'b1, 26'h0,  27'd0, 3'd7, 4'd0));
    wr_desc(4, mk_desc(1'b1, 26'h10, 27'd5, 3'd1, 4'd0));
    wr_desc(5, mk_desc(1'b1, 26'h0,  27'd0, 3'd0, 4'd0));
    wr_desc(6, mk_desc(1'b1, 26'h2,  27'd0, 3'd5, 4'd1));
    wr_desc(7, mk_desc(1'b1, 26'h0,  27'd0, 3'd3, 4'd0));
    wr_desc(8, mk_desc(1'b1, 26'h0,  27'd0, 3'd4, 4'd0));
    wr_desc(9, mk_desc(1'b1, 26'h0,  27'd0, 3'd6, 4'd0));

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R2: request raised while busy is ignored
    run_vec(VECS[0], 1'b1);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (rsp_valid || mem_req_valid) extra++;
      end
      chk("R2 busy request ignored", 64'(extra), 64'd0);
    end

    // R3: rewriting a descriptor to invalid
    wr_desc(0, mk_desc(1'b0, 26'h1, 27'd0, 3'd0, 4'd0));
    walk(VECS[0], 1'b0);
    chk("R3 rewritten descriptor fault", 64'(got_fault), 64'd1);

    // R1: reset in the middle of a walk
    @(negedge clk);
    req_valid = 1'b1; req_va = 40'h800000; req_write = 1'b0; req_tsb = 5'd5;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 read pending before reset", 64'(mem_req_valid), 64'd1);
    do_reset();
    chk("R1 ready after mid-walk reset", 64'(req_ready), 64'd1);
    chk("R1 read dropped by reset", 64'(mem_req_valid), 64'd0);
    chk("R1 rsp idle after reset", 64'(rsp_valid), 64'd0);
    walk(VECS[12], 1'b0);
    chk("R1 descriptors cleared by reset", 64'(got_fault), 64'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule